// File: doc/BRIEF.md
# Tri-State Phase Comparator with Lock Flag

This block compares a divided reference pulse train against a divided oscillator pulse train, one rising edge against the next. A rising edge on the reference arms an advance flag and a rising edge on the oscillator arms a retard flag. Once both flags are armed, the comparison is over and both flags are released on the following cycle. While exactly one flag is armed, the block asks the loop to correct. It does this on two charge-pump control pins of opposite polarity. When no correction is needed, both pins are released to high impedance.

Both inputs pass through a short synchronizer in the sampling-clock domain. Each pin is modelled as a drive level plus an output enable. The tri-state pad is left to the chip level.

A lock monitor measures the error width of each comparison in sampling-clock cycles. It raises the lock flag after a run of narrow comparisons. It drops the flag as soon as a comparison grows too wide.

Top module: `phase_det_lock`

## Requirements
- R1: A rising edge on `ref_i` arms `up_o`, and a rising edge on `vco_i` arms `dn_o`. Each flag is visible after the SYNC_STAGES+1-th rising clock edge that samples the new input level. With the default of 2, that is the third edge. Falling input edges have no effect on either flag.
- R2: In the cycle that follows a cycle with both flags armed, both flags are clear. The exception is a flag whose own input edge is detected in that same cycle.
- R3: The positive pin drives level 1 with `pos_oe_o`=1 while only `up_o` is set. It drives level 0 with `pos_oe_o`=1 while only `dn_o` is set. In every other flag state, `pos_oe_o`=0 and `pos_o`=0.
- R4: The negative pin has the same enable as the positive pin and the opposite drive level. It drives 0 for an advance and 1 for a retard.
- R5: After reset, both flags are clear, both pins are high impedance and `lock_o` is 0.
- R6: A comparison counts as narrow when fewer than LOCK_WIDTH cycles (default 2) have exactly one flag set. `lock_o` rises on the edge that ends the LOCK_COUNT-th consecutive narrow comparison (default 4).
- R7: When a comparison reaches LOCK_WIDTH single-flag cycles, `lock_o` falls on the edge that closes the LOCK_WIDTH-th such cycle. The run of narrow comparisons then restarts from zero.
- R8: Reference and oscillator edges detected in the same cycle arm both flags together. Neither pin is ever enabled during that comparison.
- R9: A second rising edge on the leading input, before the lagging edge arrives, leaves its flag armed. The result is still a single continuous correction pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_i | input | 1 | Divided reference pulse train |
| vco_i | input | 1 | Divided oscillator pulse train |
| up_o | output | 1 | Advance flag |
| dn_o | output | 1 | Retard flag |
| pos_o | output | 1 | Positive pin drive level |
| pos_oe_o | output | 1 | Positive pin drive enable |
| neg_o | output | 1 | Negative pin drive level |
| neg_oe_o | output | 1 | Negative pin drive enable |
| lock_o | output | 1 | High while the loop is locked |

## Verification
The clearing property assumes that each input holds every level for at least two sampling cycles. Under that assumption, neither input can produce two detected edges one cycle apart. The bench keeps to this rule: every pulse stays high for at least two cycles and low for at least two cycles before the next rise. The error-width property counts single-flag cycles in the checker, so it assumes that a comparison ends only when both flags are armed. The stimulus always eventually delivers the lagging edge, which closes every comparison.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_UP   = 2'b01,
    ST_DN   = 2'b10,
    ST_BOTH = 2'b11
  } flag_e;

  typedef struct packed {
    logic oe;
    logic lvl;
  } pin_t;

  function automatic pin_t pin_for(flag_e s, logic invert);
    pin_t p;
    unique case (s)
      ST_UP:   p = '{oe: 1'b1, lvl: ~invert};
      ST_DN:   p = '{oe: 1'b1, lvl: invert};
      default: p = '{oe: 1'b0, lvl: 1'b0};
    endcase
    return p;
  endfunction
endpackage

// File: rtl/in_edge.sv
module in_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sig_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], sig_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[SYNC_STAGES-1];

  assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pdl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ref_rise_i,
  input  logic  vco_rise_i,
  output flag_e st_o
);
  logic up_q, dn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (up_q && dn_q) begin
      // release both; an edge seen now re-arms its own flag
      up_q <= ref_rise_i;
      dn_q <= vco_rise_i;
    end else begin
      up_q <= up_q | ref_rise_i;
      dn_q <= dn_q | vco_rise_i;
    end
  end

  assign st_o = flag_e'({dn_q, up_q});
endmodule

// File: rtl/pin_map.sv
module pin_map
  import pdl_pkg::*;
#(
  parameter bit INVERT = 1'b0
) (
  input  flag_e st_i,
  output pin_t  pin_o
);
  assign pin_o = pin_for(st_i, INVERT);
endmodule

// File: rtl/lock_mon.sv
module lock_mon
  import pdl_pkg::*;
#(
  parameter int LOCK_WIDTH = 2,
  parameter int LOCK_COUNT = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  flag_e st_i,
  output logic  lock_o
);
  localparam int WW = $clog2(LOCK_WIDTH + 1);
  localparam int CW = $clog2(LOCK_COUNT + 1);
  localparam logic [WW-1:0] W_LAST = WW'(LOCK_WIDTH - 1);
  localparam logic [WW-1:0] W_SAT  = WW'(LOCK_WIDTH);
  localparam logic [CW-1:0] C_LAST = CW'(LOCK_COUNT - 1);
  localparam logic [CW-1:0] C_SAT  = CW'(LOCK_COUNT);

  logic [WW-1:0] err_q;
  logic [CW-1:0] good_q;
  logic          wide_q, lock_q;
  logic          err, done;

  assign err  = (st_i == ST_UP) || (st_i == ST_DN);
  assign done = (st_i == ST_BOTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= '0;
      good_q <= '0;
      wide_q <= 1'b0;
      lock_q <= 1'b0;
    end else if (err) begin
      if (err_q == W_LAST) begin
        wide_q <= 1'b1;
        lock_q <= 1'b0;
        good_q <= '0;
      end
      if (err_q != W_SAT) err_q <= err_q + 1'b1;
    end else if (done) begin
      err_q  <= '0;
      wide_q <= 1'b0;
      if (!wide_q) begin
        if (good_q == C_LAST) lock_q <= 1'b1;
        if (good_q != C_SAT)  good_q <= good_q + 1'b1;
      end
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/phase_det_lock.sv
module phase_det_lock
  import pdl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_WIDTH  = 2,
  parameter int LOCK_COUNT  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic vco_i,
  output logic up_o,
  output logic dn_o,
  output logic pos_o,
  output logic pos_oe_o,
  output logic neg_o,
  output logic neg_oe_o,
  output logic lock_o
);
  localparam int NPIN = 2;

  logic  ref_rise, vco_rise;
  flag_e st;
  pin_t  pins [NPIN];

  in_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ref_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(ref_i), .rise_o(ref_rise)
  );
  in_edge #(.SYNC_STAGES(SYNC_STAGES)) u_vco_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(vco_i), .rise_o(vco_rise)
  );

  pfd_core u_core (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ref_rise_i(ref_rise), .vco_rise_i(vco_rise), .st_o(st)
  );

  // pin 0 positive polarity, pin 1 negative polarity
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    pin_map #(.INVERT(g[0])) u_map (.st_i(st), .pin_o(pins[g]));
  end

  lock_mon #(.LOCK_WIDTH(LOCK_WIDTH), .LOCK_COUNT(LOCK_COUNT)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .st_i(st), .lock_o(lock_o)
  );

  assign up_o     = st[0];
  assign dn_o     = st[1];
  assign pos_o    = pins[0].lvl;
  assign pos_oe_o = pins[0].oe;
  assign neg_o    = pins[1].lvl;
  assign neg_oe_o = pins[1].oe;
endmodule

// File: rtl/phase_det_lock_chk.sv
module phase_det_lock_chk #(
  parameter int LOCK_WIDTH = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic up_o,
  input logic dn_o,
  input logic pos_o,
  input logic pos_oe_o,
  input logic neg_o,
  input logic neg_oe_o,
  input logic lock_o
);
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          run_q <= '0;
    else if (up_o ^ dn_o) run_q <= run_q + 1;
    else                  run_q <= '0;

  // R2
  both_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o && dn_o) |=> !(up_o && dn_o));

  // R3
  pos_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_oe_o |-> (pos_o == up_o) && (up_o != dn_o));

  // R3
  pos_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o == dn_o) |-> !pos_oe_o && !pos_o);

  // R4
  neg_opposite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (neg_oe_o == pos_oe_o) && (!pos_oe_o || (neg_o != pos_o)));

  // R6
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(up_o && dn_o));

  // R7
  wide_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q >= 32'(LOCK_WIDTH)) |-> !lock_o);
endmodule

bind phase_det_lock phase_det_lock_chk #(.LOCK_WIDTH(LOCK_WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .up_o(up_o), .dn_o(dn_o),
  .pos_o(pos_o), .pos_oe_o(pos_oe_o), .neg_o(neg_o), .neg_oe_o(neg_oe_o),
  .lock_o(lock_o)
);

// File: tb/phase_det_lock_test.sv
module phase_det_lock_test;
  localparam int LW = 2;
  localparam int LC = 4;
  localparam int LAT = 3;  // SYNC_STAGES + 1

  logic clk = 1'b0, rst_n = 1'b0, ref_s = 1'b0, vco_s = 1'b0;
  logic up, dn, pos, pos_oe, neg, neg_oe, lock;
  int   n_chk = 0, n_err = 0;
  int   good_m = 0;
  logic lock_m = 1'b0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  phase_det_lock #(.SYNC_STAGES(2), .LOCK_WIDTH(LW), .LOCK_COUNT(LC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_s), .vco_i(vco_s),
    .up_o(up), .dn_o(dn), .pos_o(pos), .pos_oe_o(pos_oe),
    .neg_o(neg), .neg_oe_o(neg_oe), .lock_o(lock)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_state(string req, logic eu, logic ed, logic el);
    logic one = eu ^ ed;
    chk(req, "up", up, eu);
    chk(req, "dn", dn, ed);
    chk("R3", "pos_oe", pos_oe, one);
    chk("R3", "pos", pos, one & eu);
    chk("R4", "neg_oe", neg_oe, one);
    chk("R4", "neg", neg, one & ed);
    chk(req, "lock", lock, el);
  endtask

  // one comparison: lead edge at step 0, lag edge d steps later
  task automatic compare(bit lead_ref, int d, bit dbl);
    bit   wide = (d >= LW);
    logic nl;
    int   ng;
    string req = dbl ? "R9" : (d == 0 ? "R8" : (wide ? "R7" : "R6"));
    ng = wide ? 0 : ((good_m < LC) ? good_m + 1 : good_m);
    nl = wide ? 1'b0 : ((ng >= LC) ? 1'b1 : lock_m);
    @(negedge clk);
    if (lead_ref || d == 0) ref_s = 1'b1;
    if (!lead_ref || d == 0) vco_s = 1'b1;
    for (int k = 1; k <= d + 8; k++) begin
      logic lead_f, lag_f, el;
      @(negedge clk);
      lead_f = (k >= LAT) && (k <= LAT + d);
      lag_f  = (k == LAT + d);
      if (wide) el = (k >= LAT + LW) ? 1'b0 : lock_m;
      else      el = (k >= LAT + d + 1) ? nl : lock_m;
      chk_state(req, lead_ref ? lead_f : lag_f, lead_ref ? lag_f : lead_f, el);
      if (k == LAT) chk("R1", "flag latency", lead_ref ? up : dn, 1'b1);
      if (k == LAT + d + 1) chk("R2", "released", up | dn, 1'b0);
      if (dbl && k == 2) begin if (lead_ref) ref_s = 1'b0; else vco_s = 1'b0; end
      if (dbl && k == 4) begin if (lead_ref) ref_s = 1'b1; else vco_s = 1'b1; end
      if (k == d) begin if (lead_ref) vco_s = 1'b1; else ref_s = 1'b1; end
    end
    ref_s = 1'b0;
    vco_s = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk_state("R1", 1'b0, 1'b0, nl);
    end
    good_m = ng;
    lock_m = nl;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_state("R5", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R5", 1'b0, 1'b0, 1'b0);
    // R6: four in-phase comparisons reach lock
    for (int i = 0; i < LC; i++) compare(1'b1, 0, 1'b0);
    chk("R6", "locked", lock, 1'b1);
    compare(1'b1, 1, 1'b0);
    compare(1'b0, 1, 1'b0);
    // R7: wide comparison drops lock
    compare(1'b1, 3, 1'b0);
    chk("R7", "unlocked", lock, 1'b0);
    // sweep width and lead
    for (int d = 0; d <= 6; d++) begin
      compare(1'b1, d, 1'b0);
      compare(1'b0, d, 1'b0);
    end
    for (int i = 0; i < LC; i++) compare(i[0], 1, 1'b0);
    chk("R6", "relocked", lock, 1'b1);
    // R9: re-triggered lead input
    compare(1'b1, 6, 1'b1);
    compare(1'b0, 7, 1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule